// File: doc/BRIEF.md
# Memory-Protection Entry Register File

This block stores the per-entry settings of a physical-memory-protection unit. Each entry has an 8-bit configuration byte and an XLEN-bit address register. Software reaches both through one CSR-style port, which carries a write strobe, a selector (configuration or address), an index and a data word. Configuration bytes are packed XLEN/8 to a CSR word. Address registers are one per index. A lock scheme decides which writes land. A locked entry, or an entry pinned by a locked top-of-range neighbour above it, cannot be changed until reset.

From the stored values the block works out the start and end byte addresses of every entry. It does this in one of three matching styles: top-of-range, a four-byte granule, or a naturally aligned power-of-two range encoded by trailing ones. It also counts the entries that are switched on. Bounds, permission bits, mode, effective lock and the count go straight to a separate access checker. The outputs follow the registers with no extra delay, so the values that appear after an accepted write already reflect that write.

Top module: `pmp_regfile`

## Requirements
- R1: During and right after reset every configuration byte and address register reads zero, every entry reports mode 0 and no lock, and the active count is 0.
- R2: With csrSel=0, byte i (bits 8i+7..8i) of configuration word k is the byte of entry 4k+i. In that byte, bit 7 is the lock, bits 4:3 are the mode (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two) and bits 2:0 are read/write/execute. Reads return the stored bytes, and permBits/entryMode show bits 2:0 and 4:3 of each entry.
- R3: With csrSel=1, index j reads and writes address register j. Writes at an index of 16 or more, and configuration writes at a word index of 4 or more, change nothing. Reads there return zero.
- R4: When an entry's own lock bit is set, writes to its configuration byte and its address register are ignored. Other bytes in the same configuration word are still written.
- R5: An entry is also locked when the next-higher entry has its lock bit set and mode 1. Entry 15 is locked only by its own bit. entryLocked shows this effective lock.
- R6: In mode 1 the region ends at (address register << 2) − 1, taken modulo 2^(XLEN+2).
- R7: In mode 2 the region starts at address register << 2 and ends 3 bytes later.
- R8: In mode 3, with t the number of trailing ones in the address register, the start is the register with its low t bits cleared, shifted left by 2, and the end is start + 2^(t+3) − 1. An all-ones register covers the whole 2^(XLEN+2) space.
- R9: activeCount equals the number of entries whose mode is not 0, and it changes only after an accepted write.
- R10: In mode 0 an entry reports start 0 and end all ones.
- R11: In mode 1 the region starts at the previous entry's address register << 2, or at 0 for entry 0. Changing that previous register moves the start in the cycle right after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csrWe | input | 1 | Write strobe for the CSR port |
| csrSel | input | 1 | 0 selects configuration words, 1 selects address registers |
| csrIdx | input | 5 | Word index (configuration) or entry index (address) |
| csrWdata | input | 32 | Write data |
| csrRdata | output | 32 | Combinational read data for csrSel/csrIdx |
| regionStart | output | 544 | Start address per entry, 34 bits each, entry 0 lowest |
| regionEnd | output | 544 | End address per entry, 34 bits each |
| permBits | output | 48 | Read/write/execute bits per entry, 3 bits each |
| entryLocked | output | 16 | Effective lock per entry |
| entryMode | output | 32 | Matching mode per entry, 2 bits each |
| activeCount | output | 5 | Number of entries not in mode 0 |

## Verification
The first patterns are directed. They put each mode on its own entry with chosen address values: a zero-trailing-ones range, a few trailing ones, 31 trailing ones and all ones. These separate the power-of-two size computation from the plain shift of the four-byte case and the subtract of top-of-range. Lock patterns set a lock on an entry whose upper neighbour is off, on one whose upper neighbour is a locked top-of-range entry, and on a locked power-of-two entry that must not pin its lower neighbour. This tells the own-bit lock apart from the neighbour lock. A final stretch of random writes, mostly without lock bits, runs across valid and out-of-range indices. A behavioural model checks bounds, lock, count and readback on every cycle.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } matchMode_e;

  localparam int LOCK_POS = 7;
  localparam int MODE_LSB = 3;

  typedef struct packed {
    logic cfgStb;   // accepted cycle for a configuration word write
    logic addrStb;  // accepted cycle for an address register write
  } wrStrobe_t;

endpackage

// File: rtl/pmp_ctrl.sv
module pmp_ctrl #(
  parameter int NUM_ENTRIES = 16,
  parameter int XLEN        = 32,
  parameter int IDX_W       = 5
) (
  input  logic                   csrWe,
  input  logic                   csrSel,
  input  logic [IDX_W-1:0]       csrIdx,
  input  logic [NUM_ENTRIES-1:0] entryLocked,
  output pmp_pkg::wrStrobe_t     strb,
  output logic [NUM_ENTRIES-1:0] entryWe
);
  localparam int BPC = XLEN / 8;

  logic cfgWordOk;

  // Wide cores use only even configuration word numbers
  generate
    if (XLEN == 64) begin : g_wide
      assign cfgWordOk = ~csrIdx[0];
    end else begin : g_narrow
      assign cfgWordOk = 1'b1;
    end
  endgenerate

  assign strb.cfgStb  = csrWe & ~csrSel & cfgWordOk;
  assign strb.addrStb = csrWe & csrSel;

  // Lock decisions use the state before the write, byte by byte
  generate
    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_we
      logic cfgHit, addrHit;
      assign cfgHit  = (csrIdx == IDX_W'(e / BPC));
      assign addrHit = (csrIdx == IDX_W'(e));
      assign entryWe[e] = ~entryLocked[e] & (csrSel ? addrHit : cfgHit);
    end
  endgenerate

endmodule

// File: rtl/pmp_datapath.sv
module pmp_datapath #(
  parameter int NUM_ENTRIES = 16,
  parameter int XLEN        = 32,
  parameter int IDX_W       = 5,
  parameter int CNT_W       = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  pmp_pkg::wrStrobe_t            strb,
  input  logic [NUM_ENTRIES-1:0]        entryWe,
  input  logic                          csrSel,
  input  logic [IDX_W-1:0]              csrIdx,
  input  logic [XLEN-1:0]               csrWdata,
  output logic [XLEN-1:0]               csrRdata,
  output logic [NUM_ENTRIES*(XLEN+2)-1:0] regionStart,
  output logic [NUM_ENTRIES*(XLEN+2)-1:0] regionEnd,
  output logic [NUM_ENTRIES*3-1:0]      permBits,
  output logic [NUM_ENTRIES-1:0]        entryLocked,
  output logic [NUM_ENTRIES*2-1:0]      entryMode,
  output logic [CNT_W-1:0]              activeCount
);
  import pmp_pkg::*;

  localparam int AW  = XLEN + 2;
  localparam int BPC = XLEN / 8;
  localparam int OW  = $clog2(XLEN + 1);

  logic [7:0]      cfgQ  [NUM_ENTRIES];
  logic [XLEN-1:0] addrQ [NUM_ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        cfgQ[e]  <= '0;
        addrQ[e] <= '0;
      end
    end else begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        if (strb.cfgStb && entryWe[e]) cfgQ[e] <= csrWdata[(e % BPC)*8 +: 8];
        if (strb.addrStb && entryWe[e]) addrQ[e] <= csrWdata;
      end
    end
  end

  function automatic logic [OW-1:0] trailOnes(input logic [XLEN-1:0] v);
    logic [OW-1:0] n;
    logic stop;
    n = '0;
    stop = 1'b0;
    for (int i = 0; i < XLEN; i++) begin
      if (v[i] && !stop) n = n + OW'(1);
      else stop = 1'b1;
    end
    return n;
  endfunction

  generate
    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
      matchMode_e    mode;
      logic [AW-1:0] scaled, prevScaled, napotMask, startD, endD;
      logic [OW-1:0] ones;

      assign mode   = matchMode_e'(cfgQ[e][MODE_LSB +: 2]);
      assign scaled = {addrQ[e], 2'b00};
      assign ones   = trailOnes(addrQ[e]);
      // Shift of AW or more leaves zero, so all ones covers everything
      assign napotMask = ~({AW{1'b1}} << (int'(ones) + 3));

      if (e == 0) begin : g_first
        assign prevScaled = '0;
      end else begin : g_rest
        assign prevScaled = {addrQ[e-1], 2'b00};
      end

      if (e == NUM_ENTRIES - 1) begin : g_top
        assign entryLocked[e] = cfgQ[e][LOCK_POS];
      end else begin : g_mid
        assign entryLocked[e] = cfgQ[e][LOCK_POS] |
          (cfgQ[e+1][LOCK_POS] & (cfgQ[e+1][MODE_LSB +: 2] == MODE_TOR));
      end

      always_comb begin
        unique case (mode)
          MODE_TOR: begin
            startD = prevScaled;
            endD   = scaled - AW'(1);
          end
          MODE_NA4: begin
            startD = scaled;
            endD   = scaled | AW'(3);
          end
          MODE_NAPOT: begin
            startD = scaled & ~napotMask;
            endD   = scaled | napotMask;
          end
          default: begin
            startD = '0;
            endD   = '1;
          end
        endcase
      end

      assign regionStart[e*AW +: AW] = startD;
      assign regionEnd[e*AW +: AW]   = endD;
      assign permBits[e*3 +: 3]      = cfgQ[e][2:0];
      assign entryMode[e*2 +: 2]     = mode;
    end
  endgenerate

  always_comb begin
    activeCount = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (cfgQ[e][MODE_LSB +: 2] != MODE_OFF) activeCount = activeCount + CNT_W'(1);
    end
  end

  always_comb begin
    csrRdata = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (csrSel) begin
        if (csrIdx == IDX_W'(e)) csrRdata = addrQ[e];
      end else begin
        if (csrIdx == IDX_W'(e / BPC)) csrRdata[(e % BPC)*8 +: 8] = cfgQ[e];
      end
    end
  end

endmodule

// File: rtl/pmp_regfile.sv
module pmp_regfile #(
  parameter int NUM_ENTRIES = 16,
  parameter int XLEN        = 32,
  parameter int IDX_W       = 5,
  localparam int AW         = XLEN + 2,
  localparam int CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      csrWe,
  input  logic                      csrSel,
  input  logic [IDX_W-1:0]          csrIdx,
  input  logic [XLEN-1:0]           csrWdata,
  output logic [XLEN-1:0]           csrRdata,
  output logic [NUM_ENTRIES*AW-1:0] regionStart,
  output logic [NUM_ENTRIES*AW-1:0] regionEnd,
  output logic [NUM_ENTRIES*3-1:0]  permBits,
  output logic [NUM_ENTRIES-1:0]    entryLocked,
  output logic [NUM_ENTRIES*2-1:0]  entryMode,
  output logic [CNT_W-1:0]          activeCount
);
  pmp_pkg::wrStrobe_t     strb;
  logic [NUM_ENTRIES-1:0] entryWe;

  pmp_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .XLEN(XLEN), .IDX_W(IDX_W)) u_ctrl (
    .csrWe(csrWe), .csrSel(csrSel), .csrIdx(csrIdx),
    .entryLocked(entryLocked), .strb(strb), .entryWe(entryWe)
  );

  pmp_datapath #(.NUM_ENTRIES(NUM_ENTRIES), .XLEN(XLEN), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .entryWe(entryWe),
    .csrSel(csrSel), .csrIdx(csrIdx), .csrWdata(csrWdata), .csrRdata(csrRdata),
    .regionStart(regionStart), .regionEnd(regionEnd), .permBits(permBits),
    .entryLocked(entryLocked), .entryMode(entryMode), .activeCount(activeCount)
  );

endmodule

// File: rtl/pmp_regfile_chk.sv
module pmp_regfile_chk #(
  parameter int NUM_ENTRIES = 16,
  parameter int XLEN        = 32,
  parameter int IDX_W       = 5,
  localparam int AW         = XLEN + 2,
  localparam int CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      csrWe,
  input logic                      csrSel,
  input logic [IDX_W-1:0]          csrIdx,
  input logic [NUM_ENTRIES*AW-1:0] regionStart,
  input logic [NUM_ENTRIES*AW-1:0] regionEnd,
  input logic [NUM_ENTRIES*3-1:0]  permBits,
  input logic [NUM_ENTRIES-1:0]    entryLocked,
  input logic [NUM_ENTRIES*2-1:0]  entryMode,
  input logic [CNT_W-1:0]          activeCount
);

  AST_IDLE_COUNT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !csrWe |=> $stable(activeCount)); // R9

  AST_IDLE_LOCK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !csrWe |=> $stable(entryLocked)); // R5

  AST_OOR_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (csrWe && csrSel && (csrIdx >= IDX_W'(NUM_ENTRIES)))
      |=> ($stable(regionStart) && $stable(regionEnd))); // R3

  generate
    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_chk
      AST_LOCKED_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (csrWe && !csrSel && entryLocked[e])
          |=> ($stable(entryMode[e*2 +: 2]) && $stable(permBits[e*3 +: 3]))); // R4

      AST_LOCKED_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (csrWe && csrSel && entryLocked[e]) |=> $stable(regionEnd[e*AW +: AW])); // R4
    end
  endgenerate

endmodule

bind pmp_regfile pmp_regfile_chk #(
  .NUM_ENTRIES(NUM_ENTRIES), .XLEN(XLEN), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .csrWe(csrWe), .csrSel(csrSel), .csrIdx(csrIdx),
  .regionStart(regionStart), .regionEnd(regionEnd), .permBits(permBits),
  .entryLocked(entryLocked), .entryMode(entryMode), .activeCount(activeCount)
);

// File: tb/pmp_regfile_tb.sv
module pmp_regfile_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 16;
  localparam int XLEN  = 32;
  localparam int IDX_W = 5;
  localparam int AW    = XLEN + 2;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csrWe = 1'b0;
  logic csrSel = 1'b0;
  logic [IDX_W-1:0] csrIdx = '0;
  logic [XLEN-1:0] csrWdata = '0;
  logic [XLEN-1:0] csrRdata;
  logic [N*AW-1:0] regionStart, regionEnd;
  logic [N*3-1:0] permBits;
  logic [N-1:0] entryLocked;
  logic [N*2-1:0] entryMode;
  logic [CNT_W-1:0] activeCount;

  pmp_regfile #(.NUM_ENTRIES(N), .XLEN(XLEN), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .csrWe(csrWe), .csrSel(csrSel), .csrIdx(csrIdx),
    .csrWdata(csrWdata), .csrRdata(csrRdata), .regionStart(regionStart),
    .regionEnd(regionEnd), .permBits(permBits), .entryLocked(entryLocked),
    .entryMode(entryMode), .activeCount(activeCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0]  mCfg  [N];
  logic [31:0] mAddr [N];
  int vectors = 0;
  int misses = 0;

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit mLocked(int e);
    if (mCfg[e][7]) return 1'b1;
    if (e == N-1) return 1'b0;
    return mCfg[e+1][7] && (mCfg[e+1][4:3] == 2'd1);
  endfunction

  function automatic void mBounds(int e, output logic [AW-1:0] s, output logic [AW-1:0] en);
    logic [AW-1:0] sc;
    longint size, base, full;
    int t;
    sc = {mAddr[e], 2'b00};
    case (mCfg[e][4:3])
      2'd1: begin
        s  = (e == 0) ? '0 : {mAddr[e-1], 2'b00};
        en = sc - 34'd1;
      end
      2'd2: begin
        s  = sc;
        en = sc + 34'd3;
      end
      2'd3: begin
        t = 0;
        while (t < 32 && mAddr[e][t]) t++;
        if (t == 32) begin
          s = '0; en = '1;
        end else begin
          size = longint'(1) << (t + 3);
          full = longint'(sc);
          base = (full / size) * size;
          s  = base[AW-1:0];
          full = base + size - 1;
          en = full[AW-1:0];
        end
      end
      default: begin
        s = '0; en = '1;
      end
    endcase
  endfunction

  function automatic logic [31:0] mRead(bit sel, int idx);
    logic [31:0] r = '0;
    if (sel) begin
      if (idx < N) r = mAddr[idx];
    end else begin
      for (int b = 0; b < 4; b++)
        if (idx*4 + b < N) r[b*8 +: 8] = mCfg[idx*4 + b];
    end
    return r;
  endfunction

  task automatic compareAll();
    logic [AW-1:0] s, en;
    int cnt = 0;
    for (int e = 0; e < N; e++) begin
      mBounds(e, s, en);
      case (mCfg[e][4:3])
        2'd1: begin
          check("R11", $sformatf("start[%0d]", e), 64'(regionStart[e*AW +: AW]), 64'(s));
          check("R6", $sformatf("end[%0d]", e), 64'(regionEnd[e*AW +: AW]), 64'(en));
        end
        2'd2: begin
          check("R7", $sformatf("start[%0d]", e), 64'(regionStart[e*AW +: AW]), 64'(s));
          check("R7", $sformatf("end[%0d]", e), 64'(regionEnd[e*AW +: AW]), 64'(en));
        end
        2'd3: begin
          check("R8", $sformatf("start[%0d]", e), 64'(regionStart[e*AW +: AW]), 64'(s));
          check("R8", $sformatf("end[%0d]", e), 64'(regionEnd[e*AW +: AW]), 64'(en));
        end
        default: begin
          check("R10", $sformatf("start[%0d]", e), 64'(regionStart[e*AW +: AW]), 64'(s));
          check("R10", $sformatf("end[%0d]", e), 64'(regionEnd[e*AW +: AW]), 64'(en));
        end
      endcase
      check("R2", $sformatf("perm[%0d]", e), 64'(permBits[e*3 +: 3]), 64'(mCfg[e][2:0]));
      check("R2", $sformatf("mode[%0d]", e), 64'(entryMode[e*2 +: 2]), 64'(mCfg[e][4:3]));
      check(mCfg[e][7] ? "R4" : "R5", $sformatf("lock[%0d]", e),
            64'(entryLocked[e]), 64'(mLocked(e)));
      if (mCfg[e][4:3] != 2'd0) cnt++;
    end
    check("R9", "count", 64'(activeCount), 64'(cnt));
  endtask

  // Drive at the falling edge, check readback, commit at rising edge, compare after it
  task automatic step(bit we, bit sel, int idx, logic [31:0] data);
    bit lk [N];
    csrWe = we; csrSel = sel; csrIdx = IDX_W'(idx); csrWdata = data;
    #1;
    check(sel ? "R3" : "R2", $sformatf("read sel=%0d idx=%0d", sel, idx),
          64'(csrRdata), 64'(mRead(sel, idx)));
    @(posedge clk);
    if (we) begin
      for (int e = 0; e < N; e++) lk[e] = mLocked(e);
      if (sel) begin
        if (idx < N && !lk[idx]) mAddr[idx] = data;
      end else begin
        for (int b = 0; b < 4; b++)
          if (idx*4 + b < N && !lk[idx*4 + b]) mCfg[idx*4 + b] = data[b*8 +: 8];
      end
    end
    @(negedge clk);
    csrWe = 1'b0;
    compareAll();
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    misses++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    for (int e = 0; e < N; e++) begin mCfg[e] = '0; mAddr[e] = '0; end
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check("R1", "count in reset", 64'(activeCount), 64'd0);
    check("R1", "locks in reset", 64'(entryLocked), 64'd0);
    check("R1", "modes in reset", 64'(entryMode), 64'd0);
    #1;
    check("R1", "cfg read in reset", 64'(csrRdata), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    compareAll();

    // Address registers, including power-of-two corner values
    for (int e = 0; e < N; e++) step(1, 1, e, 32'h0000_1000 + 32'(e) * 32'h100);
    step(1, 1, 3, 32'h0000_2003);
    step(1, 1, 6, 32'hFFFF_FFFF);
    step(1, 1, 9, 32'h0000_4000);
    step(1, 1, 12, 32'h7FFF_FFFF);
    // R3: out-of-range indices
    step(1, 1, 20, 32'hDEAD_BEEF);
    step(0, 1, 20, 0);
    step(1, 0, 5, 32'hFFFF_FFFF);
    step(0, 0, 7, 0);

    // R2: configuration packing, every mode present
    step(1, 0, 0, 32'h1F04_0B11);
    step(1, 0, 1, 32'h0018_1909);
    step(1, 0, 2, 32'h0F13_1B0B);
    step(1, 0, 3, 32'h0C12_001F);
    for (int k = 0; k < 4; k++) step(0, 0, k, 0);
    for (int e = 0; e < N; e++) step(0, 1, e, 0);

    // R11: moving entry 7 moves the top-of-range start of entry 8
    step(1, 1, 7, 32'h0000_3000);

    // R4: own lock on entry 2
    step(1, 0, 0, 32'h1F84_0B11);
    step(1, 0, 0, 32'h0000_0000);
    step(1, 1, 2, 32'h0000_5555);
    step(0, 0, 0, 0);

    // R5: locked top-of-range entry 5 pins entry 4
    step(1, 0, 1, 32'h0018_8909);
    step(1, 1, 4, 32'h0000_7777);
    step(1, 1, 5, 32'h0000_8888);
    step(1, 0, 1, 32'h0000_0000);
    step(0, 0, 1, 0);

    // R5: locked power-of-two entry 13 leaves 12 free; locked top entry pins 14
    step(1, 0, 3, 32'h8C12_981F);
    step(1, 1, 12, 32'h0000_0123);
    step(1, 1, 14, 32'h0000_0456);
    step(1, 0, 3, 32'h0000_0000);
    step(0, 0, 3, 0);

    // Mixed random traffic, lock bits rare
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d = $urandom;
      if ($urandom % 16 != 0) d = d & 32'h7F7F_7F7F;
      step(bit'($urandom % 2), bit'($urandom % 2), int'($urandom % 20), d);
    end

    finishRun();
  end

endmodule